// File: doc/BRIEF.md
# Auxiliary Register Address Arithmetic Unit

This block keeps eight 16-bit auxiliary address registers for a data path that uses indirect memory operands. On each access the caller names one register and a 4-bit modification code. The block then shows the register's present value as the effective address and, on the same clock edge, writes a modified value back. The modifications are: hold, plus or minus one, plus or minus a step input, plus or minus index register 0, a circular (modulo) variant of several of these, and a bit-reversed add or subtract of index register 0. The bit-reversed form lets a radix-2 FFT step through its operands in scrambled order.

In circular mode a buffer length sets the index field. That field is the low N bits of the register, where N is the smallest value with 2^N greater than the length. Only this field moves and wraps. The upper bits act as the aligned buffer base and stay fixed. A length of zero turns wrapping off, and the circular codes then update the register linearly. A separate write port loads any register with a value.

Top module: `aux_addr_unit`

## Requirements
- R1: While reset is high on a clock edge, every auxiliary register is cleared to 0x0000.
- R2: `eff_addr` always shows the present value of the register chosen by `acc_sel` (post-modify). `upd_addr` shows the modified value, which that register holds after the edge on which `acc_valid` is high.
- R3: The linear codes work modulo 2^16. Codes 0, 13 and 15 hold the value. Code 1 subtracts 1, code 2 adds 1, code 3 adds `acc_step`, code 12 subtracts `acc_step`, code 5 subtracts register 0 and code 6 adds register 0.
- R4: The circular codes move the index by a signed amount: code 8 by -1, code 9 by +1, code 10 by minus register 0, code 11 by plus register 0, code 14 by plus `acc_step`. Let i be the index and d the amount. If i+d lies in 0..L-1, the new index is i+d. If i+d is at least L, the new index is i+d-L. If i+d is below 0, the new index is i+d+L. L is `buf_len`.
- R5: In circular mode with a non-zero `buf_len`, the bits above the index field do not change.
- R6: When `buf_len` is 0, the circular codes update the whole register linearly by the same signed amount.
- R7: Code 7 adds register 0 with reversed carry. Code 4 subtracts it with reversed borrow. The result equals the bit-reversal of the sum (or difference) of the bit-reversed operands, truncated to 16 bits.
- R8: A write with `wr_en` loads `wr_data` into register `wr_sel`. If that register is also being updated by an access in the same cycle, the write wins. An access to a different register in that cycle still takes effect.
- R9: When `acc_valid` and `wr_en` are both low, no register changes, whatever the mode inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access happens this cycle; write back the modified value |
| acc_sel | input | 3 | Register used for the access |
| acc_mod | input | 4 | Modification code |
| acc_step | input | 16 | Unsigned step for codes 3, 12 and 14 |
| buf_len | input | 16 | Circular buffer length; 0 turns wrapping off |
| wr_en | input | 1 | Load a register |
| wr_sel | input | 3 | Register to load |
| wr_data | input | 16 | Load value |
| eff_addr | output | 16 | Effective address (selected register before update) |
| upd_addr | output | 16 | Modified register value |

## Verification
The index-range assertion assumes the index already lies below `buf_len` and that the amount moved in one access is no larger than `buf_len`. Under those conditions a single correction by plus or minus L always brings the index back into range. The random stimulus keeps to this. Before each circular access it loads the selected register with an aligned base plus an index below the length, and it draws register 0 and the step from 0..L. Linear and bit-reversed accesses have no such condition, so they run on registers with any contents.

// File: rtl/aru_pkg.sv
package aru_pkg;

    localparam int unsigned AW   = 16;
    localparam int unsigned NREG = 8;
    localparam int unsigned SELW = $clog2(NREG);
    localparam int unsigned MODW = 4;

    typedef logic [AW-1:0]        word_t;
    typedef logic signed [AW:0]   delta_t;

    typedef enum logic [1:0] {K_HOLD, K_LIN, K_CIRC, K_REV} kind_e;
    typedef enum logic [1:0] {S_ZERO, S_ONE, S_IDX, S_STEP} src_e;

    typedef struct packed {
        kind_e kind;
        src_e  src;
        logic  neg;
    } op_t;

    // Modification code to operation.
    function automatic op_t decode_mod(input logic [MODW-1:0] m);
        op_t o;
        o = '{K_HOLD, S_ZERO, 1'b0};
        case (m)
            4'd1:  o = '{K_LIN,  S_ONE,  1'b1};
            4'd2:  o = '{K_LIN,  S_ONE,  1'b0};
            4'd3:  o = '{K_LIN,  S_STEP, 1'b0};
            4'd4:  o = '{K_REV,  S_IDX,  1'b1};
            4'd5:  o = '{K_LIN,  S_IDX,  1'b1};
            4'd6:  o = '{K_LIN,  S_IDX,  1'b0};
            4'd7:  o = '{K_REV,  S_IDX,  1'b0};
            4'd8:  o = '{K_CIRC, S_ONE,  1'b1};
            4'd9:  o = '{K_CIRC, S_ONE,  1'b0};
            4'd10: o = '{K_CIRC, S_IDX,  1'b1};
            4'd11: o = '{K_CIRC, S_IDX,  1'b0};
            4'd12: o = '{K_LIN,  S_STEP, 1'b1};
            4'd14: o = '{K_CIRC, S_STEP, 1'b0};
            default: o = '{K_HOLD, S_ZERO, 1'b0};
        endcase
        return o;
    endfunction

    function automatic word_t rev_bits(input word_t v);
        word_t r;
        for (int k = 0; k < int'(AW); k++) r[k] = v[AW-1-k];
        return r;
    endfunction

    // All ones at and below the top set bit of len: 2^N - 1.
    function automatic word_t len_mask(input word_t len);
        word_t m;
        m = len;
        for (int s = 1; s < int'(AW); s = s * 2) m = m | (m >> s);
        return m;
    endfunction

endpackage

// File: rtl/aru_bank.sv
module aru_bank
    import aru_pkg::*;
#(
    parameter int unsigned N  = NREG,
    parameter int unsigned W  = AW,
    localparam int unsigned SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_en,
    input  logic [SW-1:0] upd_sel,
    input  logic [W-1:0]  upd_val,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic [SW-1:0] rd_sel,
    output logic [W-1:0]  rd_val,
    output logic [W-1:0]  idx0
);

    logic [N-1:0][W-1:0] regs_q;
    logic [N-1:0]        wr_hit;
    logic [N-1:0]        up_hit;

    for (genvar g = 0; g < int'(N); g++) begin : g_hit
        assign wr_hit[g] = wr_en  && (wr_sel  == SW'(g));
        assign up_hit[g] = upd_en && (upd_sel == SW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            for (int k = 0; k < int'(N); k++) begin
                if (wr_hit[k])      regs_q[k] <= wr_data;
                else if (up_hit[k]) regs_q[k] <= upd_val;
            end
        end
    end

    assign rd_val = regs_q[rd_sel];
    assign idx0   = regs_q[0];

    p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (regs_q == '0));

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !wr_en) |=> $stable(regs_q));

    p_wr_load_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (regs_q[$past(wr_sel)] == $past(wr_data)));

    p_postmod_r2: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !(wr_en && wr_sel == upd_sel)) |=>
        (regs_q[$past(upd_sel)] == $past(upd_val)));

endmodule

// File: rtl/aru_circ.sv
module aru_circ
    import aru_pkg::*;
(
    input  word_t  cur,
    input  delta_t delta,
    input  word_t  len,
    output word_t  res
);

    word_t                 mask;
    logic signed [AW+1:0]  sum;
    logic signed [AW+1:0]  len_s;
    logic signed [AW+1:0]  wrapped;

    always_comb begin
        mask  = len_mask(len);
        len_s = $signed({2'b00, len});
        sum   = $signed({2'b00, cur & mask}) + $signed({delta[AW], delta});
        if (sum < 0)           wrapped = sum + len_s;
        else if (sum >= len_s) wrapped = sum - len_s;
        else                   wrapped = sum;
        res = (cur & ~mask) | (wrapped[AW-1:0] & mask);
    end

endmodule

// File: rtl/aru_revc.sv
module aru_revc
    import aru_pkg::*;
(
    input  word_t a,
    input  word_t b,
    input  logic  neg,
    output word_t res
);

    word_t ra, rb, rs;

    always_comb begin
        ra  = rev_bits(a);
        rb  = rev_bits(b);
        rs  = neg ? (ra - rb) : (ra + rb);
        res = rev_bits(rs);
    end

endmodule

// File: rtl/aux_addr_unit.sv
module aux_addr_unit
    import aru_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic [SELW-1:0] acc_sel,
    input  logic [MODW-1:0] acc_mod,
    input  logic [AW-1:0]   acc_step,
    input  logic [AW-1:0]   buf_len,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [AW-1:0]   wr_data,
    output logic [AW-1:0]   eff_addr,
    output logic [AW-1:0]   upd_addr
);

    op_t    op;
    word_t  cur, ar0, mag, lin_val, circ_val, rev_val;
    delta_t delta;

    aru_bank #(.N(NREG), .W(AW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (acc_valid),
        .upd_sel (acc_sel),
        .upd_val (upd_addr),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (acc_sel),
        .rd_val  (cur),
        .idx0    (ar0)
    );

    always_comb begin
        op = decode_mod(acc_mod);
        case (op.src)
            S_ONE:   mag = word_t'(1);
            S_IDX:   mag = ar0;
            S_STEP:  mag = acc_step;
            default: mag = '0;
        endcase
        delta   = op.neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
        lin_val = cur + delta[AW-1:0];
    end

    aru_circ u_circ (
        .cur   (cur),
        .delta (delta),
        .len   (buf_len),
        .res   (circ_val)
    );

    aru_revc u_revc (
        .a   (cur),
        .b   (ar0),
        .neg (op.neg),
        .res (rev_val)
    );

    always_comb begin
        case (op.kind)
            K_LIN:   upd_addr = lin_val;
            K_CIRC:  upd_addr = (buf_len == '0) ? lin_val : circ_val;
            K_REV:   upd_addr = rev_val;
            default: upd_addr = cur;
        endcase
    end

    assign eff_addr = cur;

    // Circular checks use their own mask, built apart from the datapath.
    word_t chk_mask;
    always_comb chk_mask = len_mask(buf_len);

    p_circ_base_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && op.kind == K_CIRC && buf_len != '0) |->
        ((upd_addr & ~chk_mask) == (eff_addr & ~chk_mask)));

    p_circ_range_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && op.kind == K_CIRC && buf_len != '0 &&
         (eff_addr & chk_mask) < buf_len && mag <= buf_len) |->
        ((upd_addr & chk_mask) < buf_len));

endmodule

// File: tb/sim_aux_addr_unit.sv
`timescale 1ns/1ps
module sim_aux_addr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_sel = '0;
    logic [3:0]  acc_mod = '0;
    logic [15:0] acc_step = '0;
    logic [15:0] buf_len = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] eff_addr, upd_addr;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] model [8];

    always #2 clk = ~clk;

    aux_addr_unit u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_sel(acc_sel),
        .acc_mod(acc_mod), .acc_step(acc_step), .buf_len(buf_len),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .eff_addr(eff_addr), .upd_addr(upd_addr)
    );

    function automatic logic [15:0] brev(input logic [15:0] v);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[k] = v[15-k];
        return r;
    endfunction

    function automatic logic [15:0] circ(input logic [15:0] cur, input int d, input int len);
        int n, m, i, s;
        if (len == 0) return cur + 16'(d);
        n = 0;
        while ((1 << n) <= len) n++;
        m = (1 << n) - 1;
        i = int'(cur) & m;
        s = i + d;
        if (s < 0) s = s + len;
        else if (s >= len) s = s - len;
        return (cur & ~16'(m)) | (16'(s) & 16'(m));
    endfunction

    function automatic logic [15:0] exp_next(input logic [15:0] cur, input logic [15:0] a0,
                                             input int mod, input int step, input int len);
        case (mod)
            1:  return cur - 16'd1;
            2:  return cur + 16'd1;
            3:  return cur + 16'(step);
            4:  return brev(brev(cur) - brev(a0));
            5:  return cur - a0;
            6:  return cur + a0;
            7:  return brev(brev(cur) + brev(a0));
            8:  return circ(cur, -1, len);
            9:  return circ(cur, 1, len);
            10: return circ(cur, -int'(a0), len);
            11: return circ(cur, int'(a0), len);
            12: return cur - 16'(step);
            14: return circ(cur, step, len);
            default: return cur;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // One cycle: optional access and optional write, checked before the edge.
    task automatic cyc(input logic av, input int sel, input int mod, input int step,
                       input int len, input logic we, input int ws, input int wd,
                       input string tag);
        logic [15:0] e;
        @(negedge clk);
        acc_valid = av; acc_sel = 3'(sel); acc_mod = 4'(mod);
        acc_step = 16'(step); buf_len = 16'(len);
        wr_en = we; wr_sel = 3'(ws); wr_data = 16'(wd);
        #1;
        e = exp_next(model[sel], model[0], mod, step, len);
        chk({tag, " R2 eff_addr"}, eff_addr, model[sel]);
        chk({tag, " upd_addr"}, upd_addr, e);
        @(posedge clk);
        if (av) model[sel] = e;
        if (we) model[ws] = 16'(wd);
    endtask

    task automatic acc(input int sel, input int mod, input int step, input int len, input string tag);
        cyc(1'b1, sel, mod, step, len, 1'b0, 0, 0, tag);
    endtask

    task automatic wr(input int sel, input int d);
        cyc(1'b0, 0, 0, 0, 0, 1'b1, sel, d, "load R8");
    endtask

    task automatic peek(input int sel, input string tag);
        cyc(1'b0, sel, 0, 0, 0, 1'b0, 0, 0, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lin_codes [11] = '{0, 1, 2, 3, 4, 5, 6, 7, 12, 13, 15};
        int circ_codes [5] = '{8, 9, 10, 11, 14};
        void'($urandom(32'd2024));
        for (int k = 0; k < 8; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: all registers zero after reset
        for (int k = 0; k < 8; k++) peek(k, "R1 reset");

        // R3: linear codes
        wr(0, 16'h0010);
        wr(1, 16'h0000);
        acc(1, 1, 0, 0, "R3 dec wraps");
        acc(1, 2, 0, 0, "R3 inc");
        acc(1, 3, 16'h1234, 0, "R3 add step");
        acc(1, 12, 16'h0100, 0, "R3 sub step");
        acc(1, 6, 0, 0, "R3 add ar0");
        acc(1, 5, 0, 0, "R3 sub ar0");
        acc(1, 13, 0, 0, "R3 hold");

        // R4 R5: 32-entry circular walk, base aligned to 64
        wr(2, 16'h1240);
        for (int k = 0; k < 40; k++) acc(2, 14, 5, 32, "R4 R5 circ walk");
        wr(3, 16'h1240);
        acc(3, 8, 0, 32, "R4 dec below zero");
        acc(3, 9, 0, 32, "R4 inc at top");
        wr(0, 16'd32);
        acc(3, 11, 0, 32, "R4 add full length");
        acc(3, 10, 0, 32, "R4 sub full length");

        // R6: zero length is linear
        wr(4, 16'h00FF);
        acc(4, 9, 0, 0, "R6 linear inc");
        acc(4, 14, 16'h0F00, 0, "R6 linear step");

        // R7: 16-point bit-reversed walk, ar0 = 8
        wr(0, 16'd8);
        wr(5, 16'h2000);
        for (int k = 0; k < 16; k++) begin
            peek(5, "R7 order");
            chk("R7 bitrev position", eff_addr, 16'h2000 | 16'(brev(16'(k)) >> 12));
            acc(5, 7, 0, 0, "R7 rev add");
        end
        acc(5, 4, 0, 0, "R7 rev sub");
        acc(5, 4, 0, 0, "R7 rev sub");

        // R8: write wins on same register, other register still updates
        wr(6, 16'h0100);
        cyc(1'b1, 6, 2, 0, 0, 1'b1, 6, 16'h5555, "R8 conflict");
        peek(6, "R8 write won");
        cyc(1'b1, 6, 2, 0, 0, 1'b1, 7, 16'hABCD, "R8 split");
        peek(6, "R8 access applied");
        peek(7, "R8 load applied");

        // R9: idle cycles change nothing
        cyc(1'b0, 6, 2, 0, 0, 1'b0, 0, 0, "R9 idle");
        cyc(1'b0, 6, 9, 3, 8, 1'b0, 0, 0, "R9 idle");
        peek(6, "R9 unchanged");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int r;
            r = int'($urandom % 4);
            if (r == 0) begin
                wr(int'($urandom % 8), int'($urandom % 65536));
            end else if (r == 1) begin
                acc(int'($urandom % 8), lin_codes[$urandom % 11],
                    int'($urandom % 65536), 0, "R3 R7 random");
            end else begin
                int len, n, m, sel;
                len = 1 + int'($urandom % 100);
                n = 0;
                while ((1 << n) <= len) n++;
                m = (1 << n) - 1;
                sel = 1 + int'($urandom % 7);
                wr(0, int'($urandom % (len + 1)));
                wr(sel, (int'($urandom % 65536) & ~m) | int'($urandom % len));
                acc(sel, circ_codes[$urandom % 5], int'($urandom % (len + 1)),
                    len, "R4 R5 random");
            end
        end

        finish_run();
    end

endmodule